// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block watches the register numbers flowing through a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback) and decides, each cycle, where the two ALU operands of the instruction in execute should come from. An operand can come from the register file value read in decode. It can also come from the ALU result now sitting in the memory stage, or from the value about to be written back. Results therefore reach dependent instructions without waiting for writeback.

A value loaded from memory is not available early enough for the instruction that immediately follows the load. When that instruction in decode reads the load's destination, the block raises a stall. The stall freezes the PC and the fetch/decode register and injects one bubble into execute. One cycle later the load has reached writeback, and its data is bypassed from there. A dependence three instructions apart needs no bypass path. The register file writes in the first half of the cycle and reads in the second half, so decode already sees the new value. The block is purely combinational. The operand multiplexers and the register file live outside it.

Top module: `hzd_fwd_unit`

## Requirements
- R1: An execute-stage source equal to the memory-stage destination gets select 2'b10 (memory-stage ALU result). This needs the memory-stage write-enable set, the destination non-zero and the memory-stage instruction not a load.
- R2: An execute-stage source equal to the writeback-stage destination gets select 2'b01 (writeback value) when writeback write-enable is set, the destination is non-zero and R1 does not apply.
- R3: When both the memory-stage and writeback-stage destinations match a source, the memory-stage result (2'b10) wins.
- R4: With no qualifying match, the select is 2'b00 (register file value); a matching producer with its write-enable low does not count.
- R5: Register zero is never a bypass source and never causes a stall, even with write-enables and the load flag set.
- R6: When execute holds a load with write-enable set and either decode source equals its non-zero destination, stall_fetch_o and bubble_ex_o are both 1.
- R7: No stall occurs when a load in execute is not read by the decode instruction, or when the matching instruction in execute is not a load.
- R8: A load in the memory stage is never selected as a bypass source; the operand falls back to a writeback match (2'b01) or the register file (2'b00).
- R9: A decode source equal to the writeback destination raises no stall (distance-three dependence is left to the register file).
- R10: The two operand selects are decided independently and may differ in the same cycle.
- R11: A load in execute with write-enable low causes no stall even if its destination matches a decode source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | 2x5 | Source register numbers of the instruction in decode |
| ex_rs_i | input | 2x5 | Source register numbers of the instruction in execute |
| ex_rd_i | input | 5 | Destination register of the instruction in execute |
| ex_we_i | input | 1 | Register write-enable of the instruction in execute |
| ex_is_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | 5 | Destination register of the instruction in memory stage |
| mem_we_i | input | 1 | Register write-enable of the memory-stage instruction |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | 5 | Destination register of the writeback-stage instruction |
| wb_we_i | input | 1 | Register write-enable of the writeback-stage instruction |
| fwd_sel_o | output | 2x2 | Per-operand bypass select (00 RF, 01 writeback, 10 memory) |
| stall_fetch_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex_o | output | 1 | Insert a nop into the execute stage |

## Verification
The bench aims at the cases where two producers claim the same register. A design with the priority reversed would hand the older writeback value to the consumer. It also covers register zero with every qualifier set; a design that forgets that guard would bypass or stall on the hard-wired zero register. Loads get separate tests: one in execute with write-enable low, one in the memory stage matching a source, and a decode source equal only to the writeback destination. A design that got these wrong would stall needlessly, or would select an ALU result that does not yet hold the loaded data.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             we_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  assign hit_o = we_i && (rd_i != ZERO_REG) && (rd_i == src_i);

  always_comb begin
    if (hit_o) a_r5_zero_never_hits: assert (src_i != ZERO_REG)
      else $error("register zero produced a hit");
  end
endmodule

// File: rtl/hzd_bypass_sel.sv
module hzd_bypass_sel
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  input  logic             mem_is_load_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_we_i,
  output fwd_sel_e         sel_o
);
  logic mem_hit, wb_hit;

  hzd_src_match #(.REG_W(REG_W)) u_mem_match (
    .src_i(src_i), .rd_i(mem_rd_i), .we_i(mem_we_i), .hit_o(mem_hit)
  );

  hzd_src_match #(.REG_W(REG_W)) u_wb_match (
    .src_i(src_i), .rd_i(wb_rd_i), .we_i(wb_we_i), .hit_o(wb_hit)
  );

  // load data is not ready in the memory stage: never bypass it from there
  always_comb begin
    if (mem_hit && !mem_is_load_i) sel_o = SEL_MEM;
    else if (wb_hit)               sel_o = SEL_WB;
    else                           sel_o = SEL_RF;
  end

  always_comb begin
    if (mem_hit && !mem_is_load_i) a_r3_mem_wins: assert (sel_o == SEL_MEM)
      else $error("memory-stage match not selected");
    if (mem_is_load_i) a_r8_no_load_bypass: assert (sel_o != SEL_MEM)
      else $error("load in memory stage used as bypass source");
    if (!mem_hit && !wb_hit) a_r4_rf_default: assert (sel_o == SEL_RF)
      else $error("bypass selected without a match");
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic                          ex_we_i,
  input  logic                          ex_is_load_i,
  output logic                          stall_o
);
  logic [NUM_SRC-1:0] src_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_src_match #(.REG_W(REG_W)) u_match (
      .src_i(id_rs_i[g]), .rd_i(ex_rd_i), .we_i(ex_we_i), .hit_o(src_hit[g])
    );
  end

  assign stall_o = ex_is_load_i && (|src_hit);

  always_comb begin
    if (stall_o) a_r11_stall_needs_we: assert (ex_we_i && ex_is_load_i)
      else $error("stall without a writing load in execute");
    if (stall_o) a_r5_stall_not_zero: assert (ex_rd_i != '0)
      else $error("stall on register zero");
  end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_rs_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic                          ex_we_i,
  input  logic                          ex_is_load_i,
  input  logic [REG_W-1:0]              mem_rd_i,
  input  logic                          mem_we_i,
  input  logic                          mem_is_load_i,
  input  logic [REG_W-1:0]              wb_rd_i,
  input  logic                          wb_we_i,
  output logic [NUM_SRC-1:0][1:0]       fwd_sel_o,
  output logic                          stall_fetch_o,
  output logic                          bubble_ex_o
);
  fwd_sel_e sel [NUM_SRC];
  logic     load_stall;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    hzd_bypass_sel #(.REG_W(REG_W)) u_sel (
      .src_i        (ex_rs_i[g]),
      .mem_rd_i     (mem_rd_i),
      .mem_we_i     (mem_we_i),
      .mem_is_load_i(mem_is_load_i),
      .wb_rd_i      (wb_rd_i),
      .wb_we_i      (wb_we_i),
      .sel_o        (sel[g])
    );
    assign fwd_sel_o[g] = sel[g];
  end

  hzd_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_load_use (
    .id_rs_i     (id_rs_i),
    .ex_rd_i     (ex_rd_i),
    .ex_we_i     (ex_we_i),
    .ex_is_load_i(ex_is_load_i),
    .stall_o     (load_stall)
  );

  // a stall freezes fetch/decode and feeds a nop into execute
  assign stall_fetch_o = load_stall;
  assign bubble_ex_o   = load_stall;

  always_comb begin
    if (stall_fetch_o) a_r6_stall_has_reader: assert ((id_rs_i[0] == ex_rd_i) || (id_rs_i[1] == ex_rd_i))
      else $error("stall raised with no decode reader of the load");
  end
endmodule

// File: tb/hzd_fwd_unit_tb_top.sv
module hzd_fwd_unit_tb_top;
  localparam int REG_W = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NUM_SRC-1:0][REG_W-1:0] id_rs, ex_rs;
  logic [REG_W-1:0] ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_ld, mem_we, mem_ld, wb_we;
  logic [NUM_SRC-1:0][1:0] fwd_sel;
  logic stall, bubble;

  int total = 0;
  int bad = 0;

  hzd_fwd_unit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) dut_i (
    .id_rs_i(id_rs), .ex_rs_i(ex_rs), .ex_rd_i(ex_rd), .ex_we_i(ex_we),
    .ex_is_load_i(ex_ld), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .mem_is_load_i(mem_ld), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_sel_o(fwd_sel), .stall_fetch_o(stall), .bubble_ex_o(bubble)
  );

  task automatic clear();
    id_rs = '0; ex_rs = '0; ex_rd = '0; mem_rd = '0; wb_rd = '0;
    ex_we = 0; ex_ld = 0; mem_we = 0; mem_ld = 0; wb_we = 0;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    clear(); settle();
    chk("R4 op0 idle", fwd_sel[0], 0);
    chk("R4 op1 idle", fwd_sel[1], 0);
    chk("R7 idle stall", stall, 0);
    chk("R7 idle bubble", bubble, 0);
  endtask

  task automatic t_mem_fwd();
    clear(); ex_rs[0] = 3; ex_rs[1] = 4; mem_rd = 3; mem_we = 1; settle();
    chk("R1 mem fwd op0", fwd_sel[0], 2);
    chk("R10 op1 untouched", fwd_sel[1], 0);
  endtask

  task automatic t_wb_fwd();
    clear(); ex_rs[1] = 7; wb_rd = 7; wb_we = 1; settle();
    chk("R2 wb fwd op1", fwd_sel[1], 1);
    chk("R2 op0 rf", fwd_sel[0], 0);
  endtask

  task automatic t_priority();
    clear(); ex_rs[0] = 4; ex_rs[1] = 4; mem_rd = 4; mem_we = 1;
    wb_rd = 4; wb_we = 1; settle();
    chk("R3 prio op0", fwd_sel[0], 2);
    chk("R3 prio op1", fwd_sel[1], 2);
  endtask

  task automatic t_we_low();
    clear(); ex_rs[0] = 5; mem_rd = 5; wb_rd = 5; settle();
    chk("R4 we low op0", fwd_sel[0], 0);
  endtask

  task automatic t_zero_reg();
    clear(); mem_we = 1; wb_we = 1; ex_we = 1; ex_ld = 1; settle();
    chk("R5 zero op0", fwd_sel[0], 0);
    chk("R5 zero op1", fwd_sel[1], 0);
    chk("R5 zero stall", stall, 0);
  endtask

  task automatic t_load_use();
    clear(); ex_rd = 9; ex_we = 1; ex_ld = 1; id_rs[1] = 9; id_rs[0] = 2; settle();
    chk("R6 stall rs1", stall, 1);
    chk("R6 bubble rs1", bubble, 1);
    id_rs[0] = 9; id_rs[1] = 2; settle();
    chk("R6 stall rs0", stall, 1);
  endtask

  task automatic t_no_use();
    clear(); ex_rd = 9; ex_we = 1; ex_ld = 1; id_rs[0] = 8; id_rs[1] = 10; settle();
    chk("R7 load unused stall", stall, 0);
    ex_ld = 0; id_rs[0] = 9; settle();
    chk("R7 non-load stall", stall, 0);
    chk("R7 non-load bubble", bubble, 0);
  endtask

  task automatic t_load_in_mem();
    clear(); ex_rs[0] = 6; mem_rd = 6; mem_we = 1; mem_ld = 1; wb_rd = 6; wb_we = 1; settle();
    chk("R8 mem load falls to wb", fwd_sel[0], 1);
    wb_we = 0; settle();
    chk("R8 mem load falls to rf", fwd_sel[0], 0);
  endtask

  task automatic t_dist3();
    clear(); id_rs[0] = 11; id_rs[1] = 11; wb_rd = 11; wb_we = 1; settle();
    chk("R9 dist3 stall", stall, 0);
    chk("R9 dist3 bubble", bubble, 0);
  endtask

  task automatic t_ex_we_low();
    clear(); ex_rd = 12; ex_ld = 1; id_rs[0] = 12; settle();
    chk("R11 we low stall", stall, 0);
  endtask

  task automatic t_mixed();
    clear(); ex_rs[0] = 13; ex_rs[1] = 14; mem_rd = 13; mem_we = 1;
    wb_rd = 14; wb_we = 1; settle();
    chk("R10 mixed op0", fwd_sel[0], 2);
    chk("R10 mixed op1", fwd_sel[1], 1);
  endtask

  initial begin
    fork
      begin
        clear();
        repeat (2) @(posedge clk);
        t_reset_state();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_we_low();
        t_zero_reg();
        t_load_use();
        t_no_use();
        t_load_in_mem();
        t_dist3();
        t_ex_we_low();
        t_mixed();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule